// File: doc/BRIEF.md
# Half-Rate Interleaved Serializer

This block turns 10-bit parallel code groups, already 8b/10b coded, into an NRZ serial stream. It does not use a single full-rate shift register. Each word is split into two five-bit lanes. The even-indexed bits go to one lane and the odd-indexed bits to the other. Both lanes shift on a clock that runs at half the serial bit rate. A final 2:1 stage takes one bit from each lane per half-rate cycle. The even-lane bit fills the first half of the cycle and the odd-lane bit fills the second half.

The block runs on the half-rate clock, which is five times the word rate. A mod-5 phase counter produces `word_tick_o`, the word-rate strobe. In the half-rate cycle where this strobe is high, the upstream logic must present the next code group on `word_i`. The block captures it at the end of that cycle. Words follow each other with no gap. The block has two outputs. `pair_o` carries two bits per half-rate cycle. `serial_o` is a model of the full-rate stream, built by muxing on the level of the half-rate clock.

Top module: `half_rate_serializer`

## Requirements
- R1: At a load, bits 0, 2, 4, 6 and 8 of `word_i` go to the even lane, and bits 1, 3, 5, 7 and 9 go to the odd lane. `pair_o[0]` always carries the even-lane bit and `pair_o[1]` the odd-lane bit.
- R2: In the k-th half-rate cycle after the load edge (k = 0..4), `pair_o` equals {word[2k+1], word[2k]}. The serial order is therefore bit 0 first and bit 9 last.
- R3: `word_tick_o` is high in exactly one of every five half-rate cycles. The word is captured at the rising edge that ends that cycle, so consecutive words leave no idle slot.
- R4: Changes on `word_i` while `word_tick_o` is low have no effect on `pair_o` or `serial_o`.
- R5: While `rst_ni` is low, `pair_o` and `serial_o` are 0 and `word_tick_o` is 1. After reset, the outputs stay at 0 until the first word is loaded.
- R6: `serial_o` equals `pair_o[0]` while `clk_i` is high and `pair_o[1]` while `clk_i` is low.
- R7: A reset asserted in the middle of a word clears both lanes at once and restarts the phase counter, so the first load follows on the first rising edge after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Half-rate shift clock, five times the word rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| word_i | input | 10 | Parallel 8b/10b code group, sampled when word_tick_o is high |
| word_tick_o | output | 1 | Word-rate strobe; next word is captured at the edge ending this cycle |
| pair_o | output | 2 | Interleaved bit pair: [0] even lane (first slot), [1] odd lane (second slot) |
| serial_o | output | 1 | Modelled full-rate NRZ stream |

## Verification
The assertions assume that `word_i` is stable and meaningful only in cycles where `word_tick_o` is high. They also assume that `clk_i` has a clean duty cycle, because `serial_o` is checked against `pair_o` just before each edge of the clock. The stimulus follows the strobe: it places the intended word only in strobe cycles and drives unrelated junk in every other cycle. Any leak from the junk would then show up in the lane outputs. A sweep of all 1024 input codes checks every bit position of every word. A reset in the middle of a word checks that the phase counter restarts correctly.

// File: rtl/hrser_pkg.sv
package hrser_pkg;
  localparam int unsigned CODE_W = 10;
  localparam int unsigned NUM_LANES = 2;

  typedef struct packed {
    logic odd;
    logic even;
  } pair_t;
endpackage

// File: rtl/hrser_phase_ctr.sv
module hrser_phase_ctr #(
  parameter int unsigned PERIOD = 5,
  localparam int unsigned CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  // phase 0 is the load slot
  assign tick_o = (cnt_q == '0);
endmodule

// File: rtl/hrser_lane.sv
module hrser_lane #(
  parameter int unsigned WORD_W = 10,
  parameter int unsigned LANE   = 0,
  localparam int unsigned HALF_W = WORD_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              bit_o
);
  logic [HALF_W-1:0] pick;
  logic [HALF_W-1:0] sr_q;

  for (genvar i = 0; i < HALF_W; i++) begin : g_pick
    assign pick[i] = word_i[2*i + LANE];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sr_q <= '0;
    else if (load_i) sr_q <= pick;
    else             sr_q <= {1'b0, sr_q[HALF_W-1:1]};
  end

  assign bit_o = sr_q[0];
endmodule

// File: rtl/hrser_interleave.sv
module hrser_interleave (
  input  logic clk_i,
  input  logic even_i,
  input  logic odd_i,
  output logic serial_o
);
  // high phase = first slot (even), low phase = second slot (odd)
  always_comb serial_o = clk_i ? even_i : odd_i;
endmodule

// File: rtl/half_rate_serializer.sv
module half_rate_serializer
  import hrser_pkg::*;
#(
  parameter int unsigned WORD_W = CODE_W,
  localparam int unsigned HALF_W = WORD_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  output logic              word_tick_o,
  output logic [1:0]        pair_o,
  output logic              serial_o
);
  logic                 load;
  logic [NUM_LANES-1:0] lane_bit;
  pair_t                pair;

  hrser_phase_ctr #(.PERIOD(HALF_W)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (load)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    hrser_lane #(.WORD_W(WORD_W), .LANE(l)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load),
      .word_i (word_i),
      .bit_o  (lane_bit[l])
    );
  end

  assign pair.even = lane_bit[0];
  assign pair.odd  = lane_bit[1];

  hrser_interleave u_ilv (
    .clk_i    (clk_i),
    .even_i   (pair.even),
    .odd_i    (pair.odd),
    .serial_o (serial_o)
  );

  assign word_tick_o = load;
  assign pair_o      = pair;
endmodule

// File: rtl/half_rate_serializer_chk.sv
module half_rate_serializer_chk #(
  parameter int unsigned WORD_W = 10,
  localparam int unsigned HALF_W = WORD_W / 2,
  localparam int unsigned GAP_W = $clog2(HALF_W) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] word_i,
  input logic              word_tick_o,
  input logic [1:0]        pair_o,
  input logic              serial_o
);
  logic [GAP_W-1:0] gap_q;
  logic             seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      gap_q  <= word_tick_o ? '0 : gap_q + 1'b1;
      seen_q <= seen_q | word_tick_o;
    end
  end

  assert_tick_due_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gap_q == GAP_W'(HALF_W - 1)) |-> word_tick_o);

  assert_tick_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_tick_o && seen_q) |-> (gap_q == GAP_W'(HALF_W - 1)));

  assert_load_first_pair_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_tick_o |=> (pair_o == $past(word_i[1:0])));

  assert_zero_before_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> (pair_o == 2'b00));

  assert_second_slot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serial_o == pair_o[1]);

  assert_first_slot_R6: assert property (@(negedge clk_i) disable iff (!rst_ni)
    serial_o == pair_o[0]);
endmodule

bind half_rate_serializer half_rate_serializer_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .word_i      (word_i),
  .word_tick_o (word_tick_o),
  .pair_o      (pair_o),
  .serial_o    (serial_o)
);

// File: tb/half_rate_serializer_bench.sv
`timescale 1ns/1ps
module half_rate_serializer_bench;
  localparam int W = 10;
  localparam int H = W / 2;
  localparam int NWORDS = 1024;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] word;
  logic         tick;
  logic [1:0]   pair;
  logic         ser;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  half_rate_serializer u_half_rate_serializer (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .word_i      (word),
    .word_tick_o (tick),
    .pair_o      (pair),
    .serial_o    (ser)
  );

  function automatic logic [W-1:0] word_of(input int j);
    return W'((j * 313 + 5) & 1023);
  endfunction

  function automatic logic [W-1:0] junk_of(input int n);
    return W'(((n * 173) ^ 'h2D5) & 1023);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one half-rate cycle after edge n; w is the word loaded at the last load edge
  task automatic cycle_check(input int n, input logic [W-1:0] w, input logic [W-1:0] next_w);
    int k;
    @(posedge clk);
    k = (n - 1) % H;
    #2;
    chk("R6 first slot", int'(ser), int'(w[2*k]));
    @(negedge clk);
    #1;
    chk("R1 even lane", int'(pair[0]), int'(w[2*k]));
    chk("R2 R4 pair order", int'(pair), int'({w[2*k+1], w[2*k]}));
    chk("R3 tick phase", int'(tick), int'((n % H) == 0));
    chk("R6 second slot", int'(ser), int'(w[2*k+1]));
    word = ((n % H) == 0) ? next_w : junk_of(n);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    word = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R5 reset pair", int'(pair), 0);
    chk("R5 reset serial", int'(ser), 0);
    chk("R5 reset tick", int'(tick), 1);
    word = word_of(0);
    rst_n = 1'b1;
    // exhaustive sweep of all codes, junk on non-load cycles
    for (int n = 1; n <= NWORDS * H; n++) begin
      cycle_check(n, word_of((n - 1) / H), word_of(n / H));
    end

    // mid-word reset
    word = 10'h3A5;
    repeat (2) @(posedge clk);
    @(negedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    chk("R7 async clear pair", int'(pair), 0);
    chk("R7 phase restart tick", int'(tick), 1);
    @(posedge clk);
    #2;
    chk("R5 held serial", int'(ser), 0);
    @(negedge clk);
    #1;
    chk("R5 held pair", int'(pair), 0);
    word = 10'h2C9;
    rst_n = 1'b1;
    for (int n = 1; n <= 2 * H; n++) begin
      cycle_check(n, (n <= H) ? 10'h2C9 : 10'h135, 10'h135);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule